// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Override

An eight-pin general-purpose I/O port controller. A direction register and an output data register sit on a small CPU register bus. For every pin, the block resolves the final pad output enable and pad output value, choosing between the GPIO registers and three on-chip serial peripherals that can claim fixed pins: one SPI and two UART-style serial channels.

The SPI claims pins 7 to 4 as a group and supplies its own per-pin output enable and data. Each serial channel claims one pin for its transmitter (forced output) and one for its receiver (forced input). Pad inputs pass through a two-flop synchronizer. The synchronized values can be read back from the bus and are routed to the peripherals' receive inputs. Register contents are kept while a peripheral owns a pin. They take effect again as soon as the peripheral's enable drops.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset the direction and data registers read 0, and all pad_oe_o and pad_out_o bits are 0.
- R2: Bus address 0 is the direction register (bit 1 = output) and address 1 is the data register. A write with sel_i and we_i high stores wdata_i at the clock edge. A read returns the stored value combinationally while sel_i is high.
- R3: For a pin that no peripheral owns, pad_oe_o equals its direction bit and pad_out_o equals its data bit.
- R4: While spi_en_i is high, pad pin 4+k takes its output enable from spi_oe_i[k] and its output value from spi_out_i[k], for k = 0..3.
- R5: While u1_tx_en_i is high, pin 3 has pad_oe_o = 1 and pad_out_o = u1_txd_i.
- R6: While u1_rx_en_i is high, pin 2 has pad_oe_o = 0 and pad_out_o = 0.
- R7: While u0_tx_en_i is high, pin 1 is an output carrying u0_txd_i. While u0_rx_en_i is high, pin 0 has pad_oe_o = 0 and pad_out_o = 0.
- R8: When a peripheral enable falls, the affected pins return to register control without waiting for a clock edge, so they are under register control by the next cycle at the latest.
- R9: Writes to the direction or data register while a peripheral owns a pin are stored and read back, but they do not change that pin's pads until the pin is released.
- R10: Address 2 returns the pad inputs after two clock edges of synchronization. Writes to address 2 are ignored. Address 3 reads 0.
- R11: spi_in_o[k] carries synchronized pad pin 4+k. u1_rxd_o carries synchronized pin 2, and u0_rxd_o carries synchronized pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus select |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| spi_en_i | input | 1 | SPI owns pins 7..4 |
| spi_oe_i | input | 4 | SPI output enables for pins 7..4 (bit 0 = pin 4) |
| spi_out_i | input | 4 | SPI output data for pins 7..4 |
| spi_in_o | output | 4 | Synchronized pin 7..4 inputs to the SPI |
| u1_tx_en_i | input | 1 | Serial 1 transmitter owns pin 3 |
| u1_txd_i | input | 1 | Serial 1 transmit data |
| u1_rx_en_i | input | 1 | Serial 1 receiver owns pin 2 |
| u1_rxd_o | output | 1 | Synchronized pin 2 to serial 1 |
| u0_tx_en_i | input | 1 | Serial 0 transmitter owns pin 1 |
| u0_txd_i | input | 1 | Serial 0 transmit data |
| u0_rx_en_i | input | 1 | Serial 0 receiver owns pin 0 |
| u0_rxd_o | output | 1 | Synchronized pin 0 to serial 0 |
| pad_in_i | input | 8 | Pad input values |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
The bench writes the direction register while the SPI owns the upper pins. A design that applies the write at once would flip those pads; a design that drops the write would show the old value after release. The bench also sets data bits that conflict with a serial transmitter's data on its pin, to catch a mux that lets the register leak through. It forces receive pins while the direction bit says output, which catches a design that drives a receive line. Finally, it samples the pin-state register one and two edges after a pad change, which exposes a missing or extra synchronizer stage.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NPINS = 8;
  localparam int unsigned SPI_W = 4;
  localparam int unsigned SPI_LO = 4;
  localparam int unsigned PIN_U1_TX = 3;
  localparam int unsigned PIN_U1_RX = 2;
  localparam int unsigned PIN_U0_TX = 1;
  localparam int unsigned PIN_U0_RX = 0;

  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_DOUT = 2'd1,
    ADDR_PIN  = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] dout_o
);
  reg_addr_e addr;
  logic      wr;
  assign addr = reg_addr_e'(addr_i);
  assign wr   = sel_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      dout_o <= '0;
    end else if (wr) begin
      if (addr == ADDR_DIR)  dir_o  <= wdata_i;
      if (addr == ADDR_DOUT) dout_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (addr)
        ADDR_DIR:  rdata_o = dir_o;
        ADDR_DOUT: rdata_o = dout_o;
        ADDR_PIN:  rdata_o = pin_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr == ADDR_DIR) |=> (dir_o == $past(wdata_i)));  // R2
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr == ADDR_DOUT) |=> $stable(dout_o));  // R2
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)              warm_q <= '0;
      else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));  // R10
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] own_i,
  input  logic [W-1:0] per_oe_i,
  input  logic [W-1:0] per_out_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] dout_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_oe_o[i]  = own_i[i] ? per_oe_i[i]  : dir_i[i];
    assign pad_out_o[i] = own_i[i] ? per_out_i[i] : dout_i[i];
  end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  input  logic             spi_en_i,
  input  logic [SPI_W-1:0] spi_oe_i,
  input  logic [SPI_W-1:0] spi_out_i,
  output logic [SPI_W-1:0] spi_in_o,
  input  logic             u1_tx_en_i,
  input  logic             u1_txd_i,
  input  logic             u1_rx_en_i,
  output logic             u1_rxd_o,
  input  logic             u0_tx_en_i,
  input  logic             u0_txd_i,
  input  logic             u0_rx_en_i,
  output logic             u0_rxd_o,
  input  logic [NPINS-1:0] pad_in_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o
);
  logic [NPINS-1:0] dir, dout, pin_sync;
  logic [NPINS-1:0] own, per_oe, per_out;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_sync)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i,
    .pin_i(pin_sync), .rdata_o, .dir_o(dir), .dout_o(dout)
  );

  // Fixed ownership map; receive pins are forced to input with idle low output
  always_comb begin
    own     = '0;
    per_oe  = '0;
    per_out = '0;
    own[SPI_LO +: SPI_W]     = {SPI_W{spi_en_i}};
    per_oe[SPI_LO +: SPI_W]  = spi_oe_i;
    per_out[SPI_LO +: SPI_W] = spi_out_i;
    own[PIN_U1_TX]     = u1_tx_en_i;
    per_oe[PIN_U1_TX]  = 1'b1;
    per_out[PIN_U1_TX] = u1_txd_i;
    own[PIN_U1_RX]     = u1_rx_en_i;
    own[PIN_U0_TX]     = u0_tx_en_i;
    per_oe[PIN_U0_TX]  = 1'b1;
    per_out[PIN_U0_TX] = u0_txd_i;
    own[PIN_U0_RX]     = u0_rx_en_i;
  end

  gpio_pin_mux #(.W(NPINS)) u_mux (
    .own_i(own), .per_oe_i(per_oe), .per_out_i(per_out),
    .dir_i(dir), .dout_i(dout), .pad_oe_o, .pad_out_o
  );

  assign spi_in_o = pin_sync[SPI_LO +: SPI_W];
  assign u1_rxd_o = pin_sync[PIN_U1_RX];
  assign u0_rxd_o = pin_sync[PIN_U0_RX];

  AST_SPI_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_en_i |-> (pad_oe_o[SPI_LO +: SPI_W] == spi_oe_i &&
                  pad_out_o[SPI_LO +: SPI_W] == spi_out_i));  // R4
  AST_U1_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u1_tx_en_i |-> (pad_oe_o[PIN_U1_TX] && pad_out_o[PIN_U1_TX] == u1_txd_i));  // R5
  AST_U1_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u1_rx_en_i |-> !pad_oe_o[PIN_U1_RX]);  // R6
  AST_U0_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u0_tx_en_i |-> (pad_oe_o[PIN_U0_TX] && pad_out_o[PIN_U0_TX] == u0_txd_i)) and
    (u0_rx_en_i |-> !pad_oe_o[PIN_U0_RX]));  // R7
  AST_SPI_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_en_i |-> (pad_oe_o[SPI_LO +: SPI_W] == dir[SPI_LO +: SPI_W]));  // R3
endmodule

// File: tb/sim_gpio_port_mux.sv
module sim_gpio_port_mux;
  localparam time TCK = 8ns;

  logic       clk = 0, rst_n = 0;
  logic       sel = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       spi_en = 0;
  logic [3:0] spi_oe = 0, spi_out = 0, spi_in;
  logic       u1_tx = 0, u1_txd = 0, u1_rx = 0, u1_rxd;
  logic       u0_tx = 0, u0_txd = 0, u0_rx = 0, u0_rxd;
  logic [7:0] pad_in = 0, pad_out, pad_oe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  gpio_port_mux u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .spi_en_i(spi_en), .spi_oe_i(spi_oe),
    .spi_out_i(spi_out), .spi_in_o(spi_in), .u1_tx_en_i(u1_tx), .u1_txd_i(u1_txd),
    .u1_rx_en_i(u1_rx), .u1_rxd_o(u1_rxd), .u0_tx_en_i(u0_tx), .u0_txd_i(u0_txd),
    .u0_rx_en_i(u0_rx), .u0_rxd_o(u0_rxd), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe)
  );

  // {dir, dout, spi_en, spi_oe, spi_out, u1_tx, u1_txd, u1_rx, u0_tx, u0_txd, u0_rx, exp_oe, exp_out}
  localparam int NV = 7;
  localparam logic [46:0] VEC [NV] = '{
    {8'hFF, 8'hA5, 1'b0, 4'h0, 4'h0, 6'b000000, 8'hFF, 8'hA5},  // R3
    {8'h00, 8'h5A, 1'b0, 4'h0, 4'h0, 6'b000000, 8'h00, 8'h5A},  // R3
    {8'h0F, 8'hFF, 1'b1, 4'h3, 4'h5, 6'b000000, 8'h3F, 8'h5F},  // R4
    {8'h00, 8'h00, 1'b0, 4'h0, 4'h0, 6'b111101, 8'h0A, 8'h08},  // R5 R6 R7
    {8'hFF, 8'hFF, 1'b0, 4'h0, 4'h0, 6'b001001, 8'hFA, 8'hFA},  // R6 R7
    {8'hF0, 8'h0F, 1'b1, 4'hF, 4'h0, 6'b000110, 8'hF2, 8'h0F},  // R4 R7
    {8'h55, 8'h3B, 1'b0, 4'h0, 4'h0, 6'b100000, 8'h5D, 8'h33}   // R5
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic periph_off();
    spi_en = 0; spi_oe = 0; spi_out = 0;
    {u1_tx, u1_txd, u1_rx, u0_tx, u0_txd, u0_rx} = '0;
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    #(TCK * 3);
    // R1 reset state
    bus_rd(2'd0, rd); check("R1 dir", rd, 8'h00);
    bus_rd(2'd1, rd); check("R1 dout", rd, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      bus_wr(2'd0, VEC[i][46:39]);
      bus_wr(2'd1, VEC[i][38:31]);
      @(negedge clk);
      spi_en = VEC[i][30]; spi_oe = VEC[i][29:26]; spi_out = VEC[i][25:22];
      {u1_tx, u1_txd, u1_rx, u0_tx, u0_txd, u0_rx} = VEC[i][21:16];
      #1;
      check($sformatf("R3-R7 vec%0d oe", i), pad_oe, VEC[i][15:8]);
      check($sformatf("R3-R7 vec%0d out", i), pad_out, VEC[i][7:0]);
      periph_off();
    end

    // R2 readback
    bus_wr(2'd0, 8'h96); bus_rd(2'd0, rd); check("R2 dir rw", rd, 8'h96);
    bus_wr(2'd1, 8'h69); bus_rd(2'd1, rd); check("R2 dout rw", rd, 8'h69);

    // R9 writes while owned are stored, not applied
    bus_wr(2'd0, 8'h00); bus_wr(2'd1, 8'h00);
    @(negedge clk); spi_en = 1; spi_oe = 4'h0; spi_out = 4'h0; u1_tx = 1; u1_txd = 0;
    bus_wr(2'd0, 8'hF8); bus_wr(2'd1, 8'hF8);
    #1;
    check("R9 oe held", pad_oe, 8'h08);
    check("R9 out held", pad_out, 8'h00);
    bus_rd(2'd0, rd); check("R9 dir stored", rd, 8'hF8);
    // R8 release without a clock edge
    @(negedge clk); #1;
    spi_en = 0; u1_tx = 0;
    #1;
    check("R8 oe released", pad_oe, 8'hF8);
    check("R8 out released", pad_out, 8'hF8);

    // R10 synchronizer latency, R11 routing
    @(negedge clk); pad_in = 8'hA5;
    @(negedge clk); sel = 1; we = 0; addr = 2'd2; #1;
    check("R10 one edge", rdata, 8'h00);
    @(negedge clk); #1;
    check("R10 two edges", rdata, 8'hA5);
    check("R11 spi_in", {4'h0, spi_in}, 8'h0A);
    check("R11 rxd", {6'h0, u1_rxd, u0_rxd}, 8'h03);
    sel = 0;
    bus_wr(2'd2, 8'h00); bus_rd(2'd2, rd); check("R10 pin write ignored", rd, 8'hA5);
    bus_wr(2'd3, 8'hFF); bus_rd(2'd3, rd); check("R10 addr3 zero", rd, 8'h00);
    bus_rd(2'd0, rd); check("R10 dir untouched", rd, 8'hF8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule